// File: doc/BRIEF.md
# Single-Stage Harmonic Cancelling Filter with Low-Pass Restoration

This block filters the direct and quadrature components of a voltage that has already been rotated into a frame turning at the grid fundamental. Each accepted sample pair goes through two parallel paths per channel. The first path subtracts the sample taken D strobes earlier from the current one and halves the result. With D equal to one sixth of a 50 Hz period at a 10 kHz sample rate, this removes the six-times and twelve-times fundamental ripple that harmonics leave in the rotating frame. That subtraction also removes the wanted DC term. A first-order low-pass path restores it, and the two path outputs are added.

The two channels share one delay memory. Each memory word holds a d/q pair, and one write pointer advances once per input strobe. The result is registered, so each output pair appears one clock after its input strobe. At 0 Hz the block has unity gain and zero phase, so a steady input is reproduced exactly once the low-pass path has settled. It is meant to sit inside a synchronisation loop, between the frame rotation and the loop controller.

Top module: `dsc_lp_filter`

## Requirements
- R1: While rst_ni is low and after its release, and before the first strobe, valid_o is 0, d_o and q_o are 0, the delay memory is treated as all zero, and both low-pass states are 0.
- R2: valid_o is 1 in exactly the cycle after a cycle with valid_i high, and is 0 otherwise.
- R3: For the first DELAY strobes after reset, the delayed tap reads as 0, so the cancellation term is floor(x/2).
- R4: After that, the cancellation term is floor((x[k] - x[k-DELAY]) / 2), where k counts strobes and DELAY defaults to 33.
- R5: The low-pass state y has 16 fractional bits and updates once per strobe as y += floor((x*2^16 - y)*A / 2^16), with A = 1441 (0.7*2*pi*50/10000 in Q0.16). Its output term is y/2^16 rounded to nearest, with halves rounded up.
- R6: d_o and q_o equal the cancellation term plus the low-pass term, saturated to the signed WIDTH-bit range (-32768..32767 by default).
- R7: A constant input held for 1000 strobes produces that same constant at the output.
- R8: The d and q channels are filtered with the same rule and do not affect each other.
- R9: In cycles with valid_i low, the delay memory, the fill count and the low-pass states do not advance, and d_o and q_o keep their values.
- R10: When the input repeats every DELAY strobes, the cancellation term is 0 and the output equals the low-pass term alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe marking a new d/q sample pair |
| d_i | input | WIDTH | Direct-axis input sample, signed |
| q_i | input | WIDTH | Quadrature-axis input sample, signed |
| valid_o | output | 1 | Output pair is valid |
| d_o | output | WIDTH | Filtered direct-axis sample, signed |
| q_o | output | WIDTH | Filtered quadrature-axis sample, signed |

## Verification
Two events can land on the same strobe: the delay line reports full, so the real tap replaces zero, and the low-pass state updates. The bench sends a steady input across strobe DELAY, where both change together. It also sends extreme alternating values, where a large cancellation term and a large low-pass term drive the sum into saturation in the same cycle. Each output pair is compared with a bench model that applies R3 to R6 separately to each channel. The stimulus includes random idle gaps, so a memory or pointer update taken on a non-strobe cycle shows up as a mismatch.

// File: rtl/dsc_lp_pkg.sv
package dsc_lp_pkg;
  localparam int unsigned NCH = 2;

  function automatic logic signed [15:0] sat16(input logic signed [17:0] v);
    if (v > 18'sd32767) return 16'sh7fff;
    if (v < -18'sd32768) return 16'sh8000;
    return v[15:0];
  endfunction
endpackage

// File: rtl/dsc_delay_ram.sv
module dsc_delay_ram #(
  parameter int unsigned WORD  = 32,
  parameter int unsigned DELAY = 33
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [WORD-1:0] wdata_i,
  output logic [WORD-1:0] tap_o
);
  localparam int unsigned PW = $clog2(DELAY);
  localparam int unsigned FW = $clog2(DELAY + 1);

  logic [WORD-1:0] mem [DELAY];
  logic [PW-1:0]   ptr_q;
  logic [FW-1:0]   fill_q;
  logic            full;

  assign full  = (fill_q == FW'(DELAY));
  // read-before-write: the slot about to be overwritten holds x[k-DELAY]
  assign tap_o = full ? mem[ptr_q] : '0;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (we_i) begin
      ptr_q <= (ptr_q == PW'(DELAY - 1)) ? '0 : ptr_q + 1'b1;
      if (!full) fill_q <= fill_q + 1'b1;
    end
  end

  a_r3_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FW'(DELAY));
  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ptr_q) && $stable(fill_q));
  a_r3_fill_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !full) |=> (fill_q == $past(fill_q) + 1'b1));
endmodule

// File: rtl/dsc_lowpass.sv
module dsc_lowpass #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned FRAC  = 16,
  parameter int unsigned COEF  = 1441
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [WIDTH-1:0] x_i,
  output logic signed [WIDTH:0]   y_o
);
  localparam int unsigned AW = WIDTH + FRAC + 2;
  localparam int unsigned PW = AW + FRAC + 2;
  localparam logic signed [PW-1:0] COEF_W = PW'(COEF);
  localparam logic signed [AW-1:0] HALF   = AW'(1) <<< (FRAC - 1);

  logic signed [AW-1:0] y_q, y_n, diff, rnd;
  logic signed [PW-1:0] prod;

  always_comb begin
    diff = (AW'(x_i) <<< FRAC) - y_q;
    prod = PW'(diff) * COEF_W;
    y_n  = y_q + AW'(prod >>> FRAC);
    rnd  = (y_n + HALF) >>> FRAC;
    y_o  = rnd[WIDTH:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_q <= '0;
    else if (en_i) y_q <= y_n;
  end

  a_r9_state_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_q));
  a_r5_moves_toward_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && diff > 0) |=> (y_q >= $past(y_q)));
endmodule

// File: rtl/dsc_lp_filter.sv
module dsc_lp_filter
  import dsc_lp_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DELAY = 33,
  parameter int unsigned FRAC  = 16,
  parameter int unsigned COEF  = 1441
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [WIDTH-1:0] d_i,
  input  logic signed [WIDTH-1:0] q_i,
  output logic                    valid_o,
  output logic signed [WIDTH-1:0] d_o,
  output logic signed [WIDTH-1:0] q_o
);
  localparam int unsigned WORD = NCH * WIDTH;

  logic signed [WIDTH-1:0] x_ch   [NCH];
  logic signed [WIDTH-1:0] xd_ch  [NCH];
  logic signed [WIDTH:0]   lp_ch  [NCH];
  logic signed [WIDTH-1:0] sum_ch [NCH];
  logic signed [WIDTH-1:0] out_q  [NCH];
  logic [WORD-1:0]         wdata, tap;

  assign x_ch[0] = d_i;
  assign x_ch[1] = q_i;
  assign wdata   = {q_i, d_i};

  dsc_delay_ram #(.WORD(WORD), .DELAY(DELAY)) i_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (valid_i),
    .wdata_i(wdata),
    .tap_o  (tap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [WIDTH:0]   dif;
    logic signed [WIDTH+1:0] total;

    assign xd_ch[c] = tap[c*WIDTH +: WIDTH];

    dsc_lowpass #(.WIDTH(WIDTH), .FRAC(FRAC), .COEF(COEF)) i_lp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (valid_i),
      .x_i   (x_ch[c]),
      .y_o   (lp_ch[c])
    );

    always_comb begin
      dif   = (WIDTH+1)'(x_ch[c]) - (WIDTH+1)'(xd_ch[c]);
      total = (WIDTH+2)'(dif >>> 1) + (WIDTH+2)'(lp_ch[c]);
      if (total > (WIDTH+2)'((2 ** (WIDTH-1)) - 1))
        sum_ch[c] = {1'b0, {(WIDTH-1){1'b1}}};
      else if (total < -(WIDTH+2)'(2 ** (WIDTH-1)))
        sum_ch[c] = {1'b1, {(WIDTH-1){1'b0}}};
      else
        sum_ch[c] = total[WIDTH-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      out_q[c] <= '0;
      else if (valid_i) out_q[c] <= sum_ch[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign d_o = out_q[0];
  assign q_o = out_q[1];

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r9_output_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(d_o) && $stable(q_o));
  a_r10_equal_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && xd_ch[0] == d_i && tap != '0) |=> (d_o == $past(sat16(18'(lp_ch[0])))));
endmodule

// File: tb/test_dsc_lp_filter.sv
module test_dsc_lp_filter;
  localparam int W = 16;
  localparam int D = 33;
  localparam longint A = 1441;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic signed [W-1:0] d_in = '0, q_in = '0;
  logic valid_o;
  logic signed [W-1:0] d_out, q_out;

  int errors = 0, checks = 0;
  int hist [2][$];
  longint yst [2];
  int cnt = 0;
  int last_exp [2];

  always #5 clk = ~clk;

  dsc_lp_filter i_dsc_lp_filter (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid),
    .d_i(d_in), .q_i(q_in), .valid_o(valid_o), .d_o(d_out), .q_o(q_out)
  );

  function automatic int sat(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // bench model of R3..R6, advancing one channel by one strobe
  function automatic int model_step(int ch, int x, output int lp_term, output int dsc_term);
    int xd;
    longint dif;
    xd  = (hist[ch].size() >= D) ? hist[ch][hist[ch].size() - D] : 0;
    dif = (longint'(x) <<< 16) - yst[ch];
    yst[ch] = yst[ch] + ((dif * A) >>> 16);
    lp_term  = int'((yst[ch] + 32768) >>> 16);
    dsc_term = int'((longint'(x) - longint'(xd)) >>> 1);
    hist[ch].push_back(x);
    if (hist[ch].size() > D + 2) void'(hist[ch].pop_front());
    return sat(longint'(dsc_term) + longint'(lp_term));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe then optional idle cycles; checks the registered output
  task automatic send(int dv, int qv, int idle, string req, bit chk_lp_only = 0);
    int ed, eq, ld, lq, sd, sq;
    @(negedge clk);
    d_in = W'(dv); q_in = W'(qv); valid = 1'b1;
    ed = model_step(0, dv, ld, sd);
    eq = model_step(1, qv, lq, sq);
    cnt++;
    @(negedge clk);
    valid = 1'b0;
    check("R2", int'(valid_o), 1);
    check(req, int'(d_out), ed);
    check(req, int'(q_out), eq);
    if (chk_lp_only) check("R10", int'(d_out), sat(ld));
    last_exp[0] = ed; last_exp[1] = eq;
    for (int i = 0; i < idle; i++) begin
      d_in = W'($urandom); q_in = W'($urandom);
      @(negedge clk);
      check("R2", int'(valid_o), 0);
      check("R9", int'(d_out), last_exp[0]);
      check("R9", int'(q_out), last_exp[1]);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    yst[0] = 0; yst[1] = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(valid_o), 0);
    check("R1", int'(d_out), 0);
    check("R1", int'(q_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(valid_o), 0);
    check("R1", int'(d_out), 0);

    // fill phase with steady input crossing strobe D (R3 then R4), channels differ (R8)
    for (int i = 0; i < D + 5; i++) send(1000, -3000, i % 2, (i < D) ? "R3" : "R4");
    // DC settling to exact value (R7)
    for (int i = 0; i < 1000; i++) send(12345, -20000, 0, "R5");
    check("R7", int'(d_out), 12345);
    check("R7", int'(q_out), -20000);
    // input repeating every D strobes: cancellation term vanishes (R10)
    for (int i = 0; i < 3 * D; i++) send((i % D) * 700 - 9000, 5, 0, "R10", i >= D);
    // extremes to force saturation (R6)
    for (int i = 0; i < 2 * D; i++)
      send(((i / 3) % 2) ? 32767 : -32768, ((i / 3) % 2) ? -32768 : 32767, 0, "R6");
    // random with idle gaps (R4, R5, R8, R9)
    for (int i = 0; i < 2000; i++)
      send(int'($signed(W'($urandom))), int'($signed(W'($urandom))), $urandom_range(0, 2), "R4");
    // q held constant while d varies: q must still reach its own DC (R8)
    for (int i = 0; i < 1000; i++) send(int'($signed(W'($urandom))), 777, 0, "R8");
    check("R8", int'(q_out), 777);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule